// File: doc/BRIEF.md
# Host Port Access Decoder with Threshold Registers

This block is the access decoder for the controlling side of a two-way buffer. Each clock, it looks at an active-low chip select, a three-bit address, a direction bit and an active-low enable. From these it sends the access to one of three places: the data queues, the one-word pass-through path, or one of four 9-bit threshold registers. The threshold registers set the almost-empty and almost-full levels of the flag logic in both directions.

Reads from any target land in a single port output register. A threshold value is placed there zero-extended. The decoder also keeps a registered pass-through mode indicator, which the far port uses to learn that bypass operation is in progress.

The block emits one-cycle strobes to the queues and the pass-through path. It honours the full and empty inhibits of the queues, and it exports the four threshold values to the flag logic. The queues themselves and the bus drivers are outside this block.

Top module: `prs_port_decoder`

## Requirements
- R1: While `cs_n` is 1, no strobe is raised, `drive_en` is 0, and neither the output register nor any threshold register changes.
- R2: An access with `cs_n`=0, `en_n`=0, `rd_wr`=0 and address 000 raises `fwd_push` in that same cycle, provided `fwd_full` is 0.
- R3: The same access with `rd_wr`=1 raises `ret_pop` in that cycle when `ret_empty` is 0. At the next rising edge, `rdata_q` takes the value of `ret_data`.
- R4: With `fwd_full`=1 no `fwd_push` occurs. With `ret_empty`=1 no `ret_pop` occurs, and `rdata_q` holds its value.
- R5: An enabled access at address 001 raises `byp_push` on a write. On a read it raises `byp_pop`, and `rdata_q` takes `byp_data` at the next edge.
- R6: An enabled write at an address 1xx stores `wdata[8:0]` at the next edge. The upper data bits are ignored. The targets are: 100 forward almost-empty (`fwd_ae_ofs`), 101 forward almost-full (`fwd_af_ofs`), 110 return almost-empty (`ret_ae_ofs`), 111 return almost-full (`ret_af_ofs`).
- R7: An enabled read at an address 1xx loads `rdata_q` with the selected threshold value, zero-extended into bits 17:9.
- R8: With `en_n`=1 no strobe is raised and neither `rdata_q` nor any threshold register changes.
- R9: After reset, all four threshold registers read 8, `rdata_q` is 0 and `bypass_mode` is 0.
- R10: `bypass_mode` becomes 1 at the edge after a cycle with `cs_n`=0 and address 001. It becomes 0 at the edge after a cycle with `cs_n`=1 or address 000. In all other cycles it holds. The enable has no effect on it.
- R11: Addresses 010 and 011 are no-ops. They raise no strobe and change neither `rdata_q`, the threshold registers nor `bypass_mode`.
- R12: `drive_en` equals 1 exactly when `cs_n`=0 and `rd_wr`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 3 | Resource select |
| rd_wr | input | 1 | 1 = read, 0 = write |
| en_n | input | 1 | Transfer enable, active low |
| wdata | input | DW | Write data from the host |
| ret_data | input | DW | Head word of the return queue |
| ret_empty | input | 1 | Return queue empty |
| byp_data | input | DW | Word waiting on the return pass-through path |
| fwd_full | input | 1 | Forward queue full |
| fwd_push | output | 1 | Push `wdata` into the forward queue |
| ret_pop | output | 1 | Pop the return queue |
| byp_push | output | 1 | Write `wdata` into the forward pass-through path |
| byp_pop | output | 1 | Consume the return pass-through word |
| rdata_q | output | DW | Port output register |
| bypass_mode | output | 1 | Pass-through mode indicator for the far port |
| drive_en | output | 1 | Bus drive direction request |
| fwd_ae_ofs | output | OW | Forward almost-empty threshold |
| fwd_af_ofs | output | OW | Forward almost-full threshold |
| ret_ae_ofs | output | OW | Return almost-empty threshold |
| ret_af_ofs | output | OW | Return almost-full threshold |

## Verification
The bench builds the block with its default widths: an 18-bit data path, 9-bit thresholds and a reset value of 8. With these widths, a random `wdata` sets bits above bit 8 most of the time. Every threshold write therefore tests that the upper bits are dropped, and every read-back tests the zero-extension. A long random run mixes all eight addresses with deasserted selects and enables and with random full and empty inhibits. This reaches the transitions of the mode indicator out of no-op and threshold cycles, which directed tests tend to miss.

// File: rtl/prs_pkg.sv
package prs_pkg;

    localparam int unsigned ADDR_W = 3;
    localparam int unsigned N_OFS  = 4;
    localparam int unsigned IDX_W  = $clog2(N_OFS);

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_FIFO = 2'd1,
        ACC_BYP  = 2'd2,
        ACC_OFS  = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/prs_decode.sv
module prs_decode
    import prs_pkg::*;
(
    input  logic              cs_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_wr,
    input  logic              en_n,
    input  logic              fwd_full,
    input  logic              ret_empty,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  ofs_idx,
    output logic              fwd_push,
    output logic              ret_pop,
    output logic              byp_push,
    output logic              byp_pop,
    output logic              ofs_we,
    output logic              rd_load,
    output logic              drive_en,
    output logic              byp_enter,
    output logic              byp_leave
);

    logic acc;

    always_comb begin
        kind    = ACC_NONE;
        ofs_idx = addr[IDX_W-1:0];
        if (!cs_n) begin
            if (addr[ADDR_W-1]) begin
                kind = ACC_OFS;
            end else if (!addr[1]) begin
                kind = addr[0] ? ACC_BYP : ACC_FIFO;
            end
        end
        acc       = !cs_n && !en_n;
        fwd_push  = acc && !rd_wr && (kind == ACC_FIFO) && !fwd_full;
        ret_pop   = acc &&  rd_wr && (kind == ACC_FIFO) && !ret_empty;
        byp_push  = acc && !rd_wr && (kind == ACC_BYP);
        byp_pop   = acc &&  rd_wr && (kind == ACC_BYP);
        ofs_we    = acc && !rd_wr && (kind == ACC_OFS);
        rd_load   = ret_pop || byp_pop || (acc && rd_wr && (kind == ACC_OFS));
        drive_en  = !cs_n && rd_wr;
        byp_enter = (kind == ACC_BYP);
        byp_leave = cs_n || (kind == ACC_FIFO);
    end

endmodule

// File: rtl/prs_ofs_bank.sv
module prs_ofs_bank
    import prs_pkg::*;
#(
    parameter int unsigned OW      = 9,
    parameter int unsigned OFS_RST = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [IDX_W-1:0]           idx,
    input  logic [OW-1:0]              wval,
    output logic [N_OFS-1:0][OW-1:0]   ofs_q
);

    localparam logic [OW-1:0] RST_VAL = OW'(OFS_RST);

    logic [N_OFS-1:0][OW-1:0] ofs_d;

    for (genvar i = 0; i < N_OFS; i++) begin : g_reg
        always_comb begin
            ofs_d[i] = ofs_q[i];
            if (we && (idx == IDX_W'(i))) begin
                ofs_d[i] = wval;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ofs_q[i] <= RST_VAL;
            end else begin
                ofs_q[i] <= ofs_d[i];
            end
        end
    end

endmodule

// File: rtl/prs_readback.sv
module prs_readback
    import prs_pkg::*;
#(
    parameter int unsigned DW = 18,
    parameter int unsigned OW = 9
) (
    input  acc_kind_e                 kind,
    input  logic [IDX_W-1:0]          ofs_idx,
    input  logic [N_OFS-1:0][OW-1:0]  ofs,
    input  logic [DW-1:0]             ret_data,
    input  logic [DW-1:0]             byp_data,
    output logic [DW-1:0]             load_val
);

    localparam int unsigned PAD_W = DW - OW;

    logic [OW-1:0] ofs_sel;

    always_comb begin
        ofs_sel = ofs[ofs_idx];
        unique case (kind)
            ACC_FIFO: load_val = ret_data;
            ACC_BYP:  load_val = byp_data;
            ACC_OFS:  load_val = {{PAD_W{1'b0}}, ofs_sel};
            default:  load_val = '0;
        endcase
    end

endmodule

// File: rtl/prs_port_decoder.sv
module prs_port_decoder
    import prs_pkg::*;
#(
    parameter int unsigned DW      = 18,
    parameter int unsigned OW      = 9,
    parameter int unsigned OFS_RST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [2:0]        addr,
    input  logic              rd_wr,
    input  logic              en_n,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     ret_data,
    input  logic              ret_empty,
    input  logic [DW-1:0]     byp_data,
    input  logic              fwd_full,
    output logic              fwd_push,
    output logic              ret_pop,
    output logic              byp_push,
    output logic              byp_pop,
    output logic [DW-1:0]     rdata_q,
    output logic              bypass_mode,
    output logic              drive_en,
    output logic [OW-1:0]     fwd_ae_ofs,
    output logic [OW-1:0]     fwd_af_ofs,
    output logic [OW-1:0]     ret_ae_ofs,
    output logic [OW-1:0]     ret_af_ofs
);

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          byp_mode;
    } port_state_t;

    port_state_t st_d, st_q;

    acc_kind_e                kind;
    logic [IDX_W-1:0]         ofs_idx;
    logic                     ofs_we, rd_load, byp_enter, byp_leave;
    logic [N_OFS-1:0][OW-1:0] ofs_all;
    logic [DW-1:0]            load_val;

    prs_decode u_decode (
        .cs_n      (cs_n),
        .addr      (addr),
        .rd_wr     (rd_wr),
        .en_n      (en_n),
        .fwd_full  (fwd_full),
        .ret_empty (ret_empty),
        .kind      (kind),
        .ofs_idx   (ofs_idx),
        .fwd_push  (fwd_push),
        .ret_pop   (ret_pop),
        .byp_push  (byp_push),
        .byp_pop   (byp_pop),
        .ofs_we    (ofs_we),
        .rd_load   (rd_load),
        .drive_en  (drive_en),
        .byp_enter (byp_enter),
        .byp_leave (byp_leave)
    );

    prs_ofs_bank #(
        .OW      (OW),
        .OFS_RST (OFS_RST)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ofs_we),
        .idx   (ofs_idx),
        .wval  (wdata[OW-1:0]),
        .ofs_q (ofs_all)
    );

    prs_readback #(
        .DW (DW),
        .OW (OW)
    ) u_readback (
        .kind     (kind),
        .ofs_idx  (ofs_idx),
        .ofs      (ofs_all),
        .ret_data (ret_data),
        .byp_data (byp_data),
        .load_val (load_val)
    );

    always_comb begin
        st_d = st_q;
        if (rd_load) begin
            st_d.rdata = load_val;
        end
        if (byp_leave) begin
            st_d.byp_mode = 1'b0;
        end else if (byp_enter) begin
            st_d.byp_mode = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_q     = st_q.rdata;
    assign bypass_mode = st_q.byp_mode;
    assign fwd_ae_ofs  = ofs_all[0];
    assign fwd_af_ofs  = ofs_all[1];
    assign ret_ae_ofs  = ofs_all[2];
    assign ret_af_ofs  = ofs_all[3];

endmodule

// File: rtl/prs_port_decoder_chk.sv
module prs_port_decoder_chk #(
    parameter int unsigned DW      = 18,
    parameter int unsigned OW      = 9,
    parameter int unsigned OFS_RST = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic [2:0]    addr,
    input logic          rd_wr,
    input logic          en_n,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] ret_data,
    input logic          ret_empty,
    input logic [DW-1:0] byp_data,
    input logic          fwd_full,
    input logic          fwd_push,
    input logic          ret_pop,
    input logic          byp_push,
    input logic          byp_pop,
    input logic [DW-1:0] rdata_q,
    input logic          bypass_mode,
    input logic          drive_en,
    input logic [OW-1:0] fwd_ae_ofs,
    input logic [OW-1:0] fwd_af_ofs,
    input logic [OW-1:0] ret_ae_ofs,
    input logic [OW-1:0] ret_af_ofs
);

    assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !(fwd_push || ret_pop || byp_push || byp_pop || drive_en));

    assert_deselect_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(rdata_q) && !bypass_mode);

    assert_no_push_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_full |-> !fwd_push);

    assert_empty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !en_n && rd_wr && addr == 3'b000 && ret_empty) |=> $stable(rdata_q));

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fwd_push, ret_pop, byp_push, byp_pop}));

    assert_ofs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !en_n && !rd_wr && addr == 3'b111) |=> ret_af_ofs == $past(wdata[OW-1:0]));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> $stable(rdata_q) && $stable({fwd_ae_ofs, fwd_af_ofs, ret_ae_ofs, ret_af_ofs}));

    assert_bypass_enter_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && addr == 3'b001) |=> bypass_mode);

    assert_noop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && addr[2:1] == 2'b01) |=> $stable(rdata_q) && $stable(bypass_mode)
            && $stable({fwd_ae_ofs, fwd_af_ofs, ret_ae_ofs, ret_af_ofs}));

    assert_drive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> (!cs_n && rd_wr));

endmodule

bind prs_port_decoder prs_port_decoder_chk #(.DW(DW), .OW(OW), .OFS_RST(OFS_RST)) u_chk (.*);

// File: tb/test_prs_port_decoder.sv
module test_prs_port_decoder;

    localparam int DW = 18;
    localparam int OW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic [2:0]    addr = '0;
    logic          rd_wr = 1'b0;
    logic          en_n = 1'b1;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] ret_data = '0;
    logic          ret_empty = 1'b0;
    logic [DW-1:0] byp_data = '0;
    logic          fwd_full = 1'b0;
    logic          fwd_push, ret_pop, byp_push, byp_pop, bypass_mode, drive_en;
    logic [DW-1:0] rdata_q;
    logic [OW-1:0] fwd_ae_ofs, fwd_af_ofs, ret_ae_ofs, ret_af_ofs;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int m_ofs [4];
    int m_rdata;
    bit m_mode;

    always #10 clk = ~clk;

    prs_port_decoder i_prs_port_decoder (.*);

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic check_regs(string req);
        check(req, int'(rdata_q), m_rdata);
        check(req, int'(bypass_mode), int'(m_mode));
        check(req, int'(fwd_ae_ofs), m_ofs[0]);
        check(req, int'(fwd_af_ofs), m_ofs[1]);
        check(req, int'(ret_ae_ofs), m_ofs[2]);
        check(req, int'(ret_af_ofs), m_ofs[3]);
    endtask

    // one access: drive, check strobes, clock, update model, check registers
    task automatic access(bit c, bit [2:0] a, bit rw, bit e, int wd, bit full, bit empty);
        bit acc;
        string tag;
        cs_n = c; addr = a; rd_wr = rw; en_n = e; wdata = DW'(wd);
        fwd_full = full; ret_empty = empty;
        ret_data = DW'($urandom); byp_data = DW'($urandom);
        #1;
        acc = !c && !e;
        tag = c ? "R1" : (e ? "R8" : (a[2:1] == 2'b01 ? "R11" : "R2"));
        check(full ? "R4" : tag, int'(fwd_push), int'(acc && !rw && a == 0 && !full));
        check(empty ? "R4" : (tag == "R2" ? "R3" : tag), int'(ret_pop), int'(acc && rw && a == 0 && !empty));
        check(tag == "R2" ? "R5" : tag, int'(byp_push), int'(acc && !rw && a == 1));
        check(tag == "R2" ? "R5" : tag, int'(byp_pop), int'(acc && rw && a == 1));
        check("R12", int'(drive_en), int'(!c && rw));
        if (acc && rw) begin
            if (a == 0 && !empty) m_rdata = int'(ret_data);
            else if (a == 1) m_rdata = int'(byp_data);
            else if (a >= 4) m_rdata = m_ofs[a - 4];
        end
        if (acc && !rw && a >= 4) m_ofs[a - 4] = wd & 511;
        if (c || a == 0) m_mode = 1'b0;
        else if (a == 1) m_mode = 1'b1;
        if (tag == "R2") tag = (a >= 4) ? (rw ? "R7" : "R6") : (a == 1 ? "R5" : (empty ? "R4" : "R3"));
        if (!c && a[2:1] != 2'b01) begin
            if (a <= 1) tag = "R10";
        end
        @(posedge clk);
        #2;
        check_regs(tag);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) m_ofs[i] = 8;
        m_rdata = 0;
        m_mode  = 1'b0;
        #35;
        check_regs("R9");
        rst_n = 1'b1;
        @(negedge clk);
        // directed: threshold write with upper bits set, then read back (R6, R7)
        access(0, 3'b100, 0, 0, 18'h3_fe05, 0, 0);
        access(0, 3'b101, 0, 0, 18'h2_01ff, 0, 0);
        access(0, 3'b110, 0, 0, 18'h0_0100, 0, 0);
        access(0, 3'b111, 0, 0, 18'h1_0000, 0, 0);
        for (int i = 4; i < 8; i++) access(0, 3'(i), 1, 0, 0, 0, 0);
        // bypass entry held through no-op and threshold access, left by deselect (R10)
        access(0, 3'b001, 1, 1, 0, 0, 0);
        access(0, 3'b010, 0, 0, 18'h3_ffff, 0, 0);
        access(0, 3'b110, 1, 0, 0, 0, 0);
        access(1, 3'b001, 0, 0, 0, 0, 0);
        access(0, 3'b001, 0, 0, 18'h1234, 0, 0);
        access(0, 3'b000, 1, 1, 0, 0, 0);
        // queue accesses with and without inhibits (R2, R3, R4)
        access(0, 3'b000, 0, 0, 18'h00aa, 0, 0);
        access(0, 3'b000, 0, 0, 18'h00bb, 1, 0);
        access(0, 3'b000, 1, 0, 0, 0, 0);
        access(0, 3'b000, 1, 0, 0, 0, 1);
        // random mix
        for (int n = 0; n < 3000; n++) begin
            access(($urandom % 8) == 0, 3'($urandom), 1'($urandom), ($urandom % 4) == 0,
                   int'(18'($urandom)), ($urandom % 4) == 0, ($urandom % 4) == 0);
        end
        finish_run();
    end

endmodule